// File: doc/BRIEF.md
# Shader Program Sequencer with Return-Address Stack

This block produces the instruction fetch address for a small programmable vertex processor. A start pulse loads a programmable entry word offset into the program counter. From then on the sequencer retires one instruction per clock. For each instruction it picks the next address from the instruction's class: step to the next word, jump to a subroutine, or return from one.

Subroutine linkage uses an eight-slot hardware stack. Every slot begins holding an "empty" marker. A call pushes the address of the call word itself, and a return resumes one word past the saved address. A return that finds the marker on top of the stack ends the program. The sequencer then drops busy and pulses done. A call made when the stack is already full does not overwrite anything: it raises a sticky error and halts.

The instruction word for the current address is presented on the decoded-instruction inputs in the same cycle. A memory read one cycle ahead, or an external prefetch, supplies it. Decode, arithmetic and the memory itself lie outside the block.

Top module: `shprog_seq`

## Requirements
- R1: An accepted start (start high while busy is low) loads entry_off into imem_addr and raises busy at the next clock edge.
- R2: While busy, op_class 2'b00 (plain) and 2'b11 (flush) each advance imem_addr by exactly one word on the next edge.
- R3: While busy and the stack is not full, a call (op_class 2'b01) pushes the call word's own address and loads call_tgt into imem_addr on the next edge.
- R4: While busy, a return (op_class 2'b10) whose top slot holds a saved address loads that address plus one (modulo 1024) into imem_addr and pops the stack.
- R5: After such a return, the slot that is now on top is overwritten with the empty marker. A later return at that level therefore ends the program, even after nested calls.
- R6: A return whose top slot holds the empty marker ends execution. done is high for exactly one cycle, and busy is low in that same cycle.
- R7: The stack holds 8 slots, and slot 0 always stays empty, so 7 calls can nest. An 8th nested call sets ovf_err and clears busy at the next edge without pulsing done. ovf_err then stays high until the next accepted start clears it.
- R8: A start pulse that arrives while busy is ignored: the address sequence continues unchanged.
- R9: During reset busy, done and ovf_err are low and imem_addr is 0.
- R10: A call placed at word 1023 is saved distinctly from the empty marker, so its return resumes at word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only while idle |
| entry_off | input | 10 | Entry word offset loaded on start |
| op_class | input | 2 | Decoded class of the current instruction (00 plain, 01 call, 10 return, 11 flush) |
| call_tgt | input | 10 | Call target word offset of the current instruction |
| imem_addr | output | 10 | Instruction memory word address (program counter) |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse when a return ends the program |
| ovf_err | output | 1 | Sticky return-stack overflow error |

## Verification
The sequencer is driven with several programs:
- A straight-line program that includes a flush word. It separates stepping from termination.
- A single call and return pair. It shows that a call saves its own word and that the return lands just after it.
- A two-deep nested call. Here the outer return must end the program because its slot was overwritten with the empty marker. This tells the stated invalidate-below rule apart from an ordinary stack.
- A chain of eight nested calls, which separates the seventh legal call from the overflowing eighth.
- A call at the last memory word, which separates a saved address of all ones from the empty marker.
- A start pulse injected mid-run, which must leave the trace unchanged.

// File: rtl/shprog_pkg.sv
package shprog_pkg;

  typedef enum logic [1:0] {
    OPC_PLAIN = 2'b00,
    OPC_CALL  = 2'b01,
    OPC_RET   = 2'b10,
    OPC_FLUSH = 2'b11
  } opclass_e;

  // one-hot-or-zero set of per-cycle sequencer events
  typedef struct packed {
    logic start;
    logic call;
    logic ovf;
    logic ret;
    logic fin;
    logic step;
  } seq_ev_t;

endpackage

// File: rtl/shprog_ctrl.sv
module shprog_ctrl
  import shprog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  opclass_e op,
  input  logic     top_empty,
  input  logic     stack_full,
  output logic     busy,
  output logic     done,
  output logic     ovf_err,
  output seq_ev_t  ev
);

  always_comb begin
    ev       = '0;
    ev.start = start & ~busy;
    if (busy) begin
      unique case (op)
        OPC_CALL: begin
          ev.call = ~stack_full;
          ev.ovf  = stack_full;
        end
        OPC_RET: begin
          ev.ret = ~top_empty;
          ev.fin = top_empty;
        end
        default: ev.step = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      done <= ev.fin;
      if (ev.start)
        busy <= 1'b1;
      else if (ev.fin || ev.ovf)
        busy <= 1'b0;
      if (ev.start)
        ovf_err <= 1'b0;
      else if (ev.ovf)
        ovf_err <= 1'b1;
    end
  end

endmodule

// File: rtl/shprog_retstack.sv
module shprog_retstack #(
  parameter int AW    = 10,
  parameter int DEPTH = 8,
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            push,
  input  logic            pop,
  input  logic [AW-1:0]   push_addr,
  output logic [AW-1:0]   top_addr,
  output logic            top_empty,
  output logic            full,
  output logic [SP_W-1:0] sp
);

  // one extra bit keeps a saved all-ones address apart from the marker
  localparam int SLOT_W = AW + 1;
  localparam logic [SLOT_W-1:0] MARK = '1;

  function automatic logic is_marker(input logic [SLOT_W-1:0] s);
    return &s;
  endfunction

  function automatic logic [SLOT_W-1:0] pack_addr(input logic [AW-1:0] a);
    return {1'b0, a};
  endfunction

  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   sp_up;
  logic [SP_W-1:0]   sp_dn;
  logic [SLOT_W-1:0] slot_w [DEPTH];
  logic [SLOT_W-1:0] top_slot;

  assign sp_up = sp_q + 1'b1;
  assign sp_dn = sp_q - 1'b1;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [SLOT_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r <= MARK;
      else if (clear)
        r <= MARK;
      else if (push && sp_up == SP_W'(g))
        r <= pack_addr(push_addr);
      else if (pop && sp_dn == SP_W'(g))
        r <= MARK;
    end
    assign slot_w[g] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp_q <= '0;
    else if (clear)
      sp_q <= '0;
    else if (push)
      sp_q <= sp_up;
    else if (pop)
      sp_q <= sp_dn;
  end

  assign top_slot  = slot_w[sp_q];
  assign top_addr  = top_slot[AW-1:0];
  assign top_empty = is_marker(top_slot);
  assign full      = (sp_q == SP_W'(DEPTH - 1));
  assign sp        = sp_q;

endmodule

// File: rtl/shprog_pc.sv
module shprog_pc #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_entry,
  input  logic          ld_call,
  input  logic          ld_ret,
  input  logic          adv,
  input  logic [AW-1:0] entry,
  input  logic [AW-1:0] call_tgt,
  input  logic [AW-1:0] ret_addr,
  output logic [AW-1:0] pc
);

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  // a return continues at the word after the saved call word
  function automatic logic [AW-1:0] resume_word(input logic [AW-1:0] saved);
    return next_word(saved);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc <= '0;
    else if (ld_entry)
      pc <= entry;
    else if (ld_call)
      pc <= call_tgt;
    else if (ld_ret)
      pc <= resume_word(ret_addr);
    else if (adv)
      pc <= next_word(pc);
  end

endmodule

// File: rtl/shprog_seq.sv
module shprog_seq
  import shprog_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] entry_off,
  input  logic [1:0]        op_class,
  input  logic [ADDR_W-1:0] call_tgt,
  output logic [ADDR_W-1:0] imem_addr,
  output logic              busy,
  output logic              done,
  output logic              ovf_err
);

  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  opclass_e          op;
  seq_ev_t           ev;
  logic              top_empty;
  logic              stack_full;
  logic [ADDR_W-1:0] top_addr;
  logic [SP_W-1:0]   sp;
  logic              ev_fin;
  logic              ev_ovf;

  assign op     = opclass_e'(op_class);
  assign ev_fin = ev.fin;
  assign ev_ovf = ev.ovf;

  shprog_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .top_empty  (top_empty),
    .stack_full (stack_full),
    .busy       (busy),
    .done       (done),
    .ovf_err    (ovf_err),
    .ev         (ev)
  );

  shprog_retstack #(.AW(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ev.start),
    .push      (ev.call),
    .pop       (ev.ret),
    .push_addr (imem_addr),
    .top_addr  (top_addr),
    .top_empty (top_empty),
    .full      (stack_full),
    .sp        (sp)
  );

  shprog_pc #(.AW(ADDR_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_entry (ev.start),
    .ld_call  (ev.call),
    .ld_ret   (ev.ret),
    .adv      (ev.step),
    .entry    (entry_off),
    .call_tgt (call_tgt),
    .ret_addr (top_addr),
    .pc       (imem_addr)
  );

endmodule

// File: rtl/shprog_seq_chk.sv
module shprog_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 8,
  localparam int SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op_class,
  input logic [ADDR_W-1:0] call_tgt,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              busy,
  input logic              done,
  input logic              ovf_err,
  input logic              stack_full,
  input logic              top_empty,
  input logic [SP_W-1:0]   sp,
  input logic              ev_fin,
  input logic              ev_ovf
);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (op_class == 2'b00 || op_class == 2'b11) |=>
      imem_addr == ADDR_W'($past(imem_addr) + 1'b1));

  // R3
  call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_class == 2'b01 && !stack_full |=>
      imem_addr == $past(call_tgt) && sp == SP_W'($past(sp) + 1'b1));

  // R5
  ret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_class == 2'b10 && !top_empty |=> top_empty);

  // R6
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_class == 2'b10 && top_empty |=> done && !busy);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done ^ ovf_err));

  // R7
  ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> ovf_err && !busy && !done);

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !(start && !busy) |=> ovf_err);

  // R6
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(ev_fin));

endmodule

bind shprog_seq shprog_seq_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .op_class   (op_class),
  .call_tgt   (call_tgt),
  .imem_addr  (imem_addr),
  .busy       (busy),
  .done       (done),
  .ovf_err    (ovf_err),
  .stack_full (stack_full),
  .top_empty  (top_empty),
  .sp         (sp),
  .ev_fin     (ev_fin),
  .ev_ovf     (ev_ovf)
);

// File: tb/sim_shprog_seq.sv
module sim_shprog_seq;
  localparam int AW = 10;
  localparam int WORDS = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] entry_off;
  logic [1:0]    op_class;
  logic [AW-1:0] call_tgt;
  logic [AW-1:0] imem_addr;
  logic          busy;
  logic          done;
  logic          ovf_err;

  logic [1:0]    prog_op  [0:WORDS-1];
  logic [AW-1:0] prog_tgt [0:WORDS-1];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int tr [0:63];
  int tn;
  int ex [0:15];
  bit fin_done;
  bit fin_ovf;

  assign op_class = prog_op[imem_addr];
  assign call_tgt = prog_tgt[imem_addr];

  shprog_seq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .entry_off (entry_off),
    .op_class  (op_class),
    .call_tgt  (call_tgt),
    .imem_addr (imem_addr),
    .busy      (busy),
    .done      (done),
    .ovf_err   (ovf_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < WORDS; i++) begin
      prog_op[i]  = 2'b00;
      prog_tgt[i] = '0;
    end
  endtask

  task automatic put(input int a, input logic [1:0] o, input int t);
    prog_op[a]  = o;
    prog_tgt[a] = AW'(t);
  endtask

  // start at entry, record each executed address; inj>=0 pulses start mid-run
  task automatic run(input int entry, input int inj);
    tn = 0;
    @(negedge clk);
    start = 1'b1;
    entry_off = AW'(entry);
    @(negedge clk);
    start = 1'b0;
    while (busy && tn < 64) begin
      tr[tn] = int'(imem_addr);
      if (tn == inj) begin
        start = 1'b1;
        entry_off = AW'(900);
      end else begin
        start = 1'b0;
      end
      tn = tn + 1;
      @(negedge clk);
    end
    start = 1'b0;
    fin_done = done;
    fin_ovf = ovf_err;
  endtask

  task automatic cmp(input string req, input int len);
    chk({req, " trace length"}, tn, len);
    for (int i = 0; i < len && i < tn; i++)
      chk({req, " trace address"}, tr[i], ex[i]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    entry_off = '0;
    clear_prog();
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", int'(busy), 0);
    chk("R9 done in reset", int'(done), 0);
    chk("R9 ovf_err in reset", int'(ovf_err), 0);
    chk("R9 address in reset", int'(imem_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_line();
    clear_prog();
    put(7, 2'b11, 0);
    put(8, 2'b10, 0);
    run(5, -1);
    chk("R1 first address is entry", tr[0], 5);
    ex[0] = 5; ex[1] = 6; ex[2] = 7; ex[3] = 8;
    cmp("R2", 4);
    chk("R6 done at end", int'(fin_done), 1);
    chk("R6 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R6 done one cycle only", int'(done), 0);
  endtask

  task automatic t_call();
    clear_prog();
    put(21, 2'b01, 100);
    put(101, 2'b10, 0);
    put(23, 2'b10, 0);
    run(20, -1);
    ex[0] = 20; ex[1] = 21; ex[2] = 100; ex[3] = 101; ex[4] = 22; ex[5] = 23;
    cmp("R3 R4", 6);
    chk("R4 done after outer return", int'(fin_done), 1);
  endtask

  task automatic t_nest();
    clear_prog();
    put(40, 2'b01, 200);
    put(200, 2'b01, 300);
    put(300, 2'b10, 0);
    put(201, 2'b10, 0);
    put(41, 2'b10, 0);
    run(40, -1);
    ex[0] = 40; ex[1] = 200; ex[2] = 300; ex[3] = 201;
    cmp("R5", 4);
    chk("R5 outer return ends program", int'(fin_done), 1);
  endtask

  task automatic t_ovf();
    clear_prog();
    for (int k = 0; k < 8; k++)
      put(600 + 10 * k, 2'b01, 610 + 10 * k);
    put(680, 2'b10, 0);
    run(600, -1);
    for (int k = 0; k < 8; k++)
      ex[k] = 600 + 10 * k;
    cmp("R7", 8);
    chk("R7 ovf_err raised", int'(fin_ovf), 1);
    chk("R7 no done on overflow", int'(fin_done), 0);
    chk("R7 busy cleared", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R7 ovf_err sticky", int'(ovf_err), 1);
    clear_prog();
    put(3, 2'b10, 0);
    run(3, -1);
    chk("R7 ovf_err cleared by start", int'(ovf_err), 0);
    chk("R7 following run completes", int'(fin_done), 1);
  endtask

  task automatic t_busy_start();
    clear_prog();
    put(710, 2'b10, 0);
    put(900, 2'b10, 0);
    run(700, 3);
    for (int k = 0; k < 11; k++)
      ex[k] = 700 + k;
    cmp("R8", 11);
    chk("R8 run ends normally", int'(fin_done), 1);
  endtask

  task automatic t_wrap();
    clear_prog();
    put(1023, 2'b01, 50);
    put(50, 2'b10, 0);
    put(0, 2'b10, 0);
    run(1023, -1);
    ex[0] = 1023; ex[1] = 50; ex[2] = 0;
    cmp("R10", 3);
    chk("R10 done at top return", int'(fin_done), 1);
  endtask

  initial begin
    t_reset();
    t_line();
    t_call();
    t_nest();
    t_ovf();
    t_busy_start();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule